// File: doc/BRIEF.md
# Banked External Data Pointer

This block sits beside an 8-bit microcontroller core and keeps two 16-bit address pointers for external data memory. Software sees only one of them at a time. That pointer appears as a low byte and a high byte in the special-function-register space, and a control register picks which of the two is the live one. The pointer that is not picked stays untouched in the background. It comes back with its old contents once the selection returns to it.

Each external data-move access that uses the pointer arrives as a one-cycle strobe. On that strobe the pointer in use can step up or down by one, as set per pointer in a mode register. The selection can also flip by itself after the access. With the flip turned on, block copies can run with one pointer as source and the other as destination, and firmware does not have to touch the select bit. The live pointer drives the 16-bit address output toward the external memory interface at all times.

Top module: `dual_dptr_unit`

## Requirements
- R1: After reset both pointers hold 0000h, pointer 0 is selected, and the control register (85h) and the step-mode register (86h) both read 00h.
- R2: A write to 82h replaces the low byte of the selected pointer, and a write to 83h replaces its high byte. The other byte keeps its value, and reads of 82h and 83h return the two bytes.
- R3: Bit 0 of 85h picks the live pointer (0 = pointer 0, 1 = pointer 1). Pointer-byte writes never alter the pointer that is not selected, and that pointer returns unchanged when it is selected again.
- R4: Bits 7 and 5..1 of 85h, and bits 7..4 of 86h, read as 0 and ignore written values.
- R5: The address output always shows the selected pointer. During a strobe cycle it shows the value before any step.
- R6: Register 86h bits [1:0] set the mode of pointer 0 and bits [3:2] set the mode of pointer 1, coded 00 = hold, 01 = add one, 10 = subtract one, 11 = hold. A strobe applies the mode of the pointer that was selected during that access, and only to that pointer.
- R7: Stepping wraps modulo 2^16: FFFFh plus one gives 0000h, and 0000h minus one gives FFFFh.
- R8: With bit 6 of 85h set, every strobe flips the selection after the access. The new selection reads back in bit 0 of 85h.
- R9: With bit 6 of 85h clear, strobes never change the selection.
- R10: When an SFR write and a strobe fall in the same cycle, the write wins. A pointer-byte write replaces the step of that pointer, and a write to 85h sets the selection instead of the automatic flip.
- R11: SFR addresses other than 82h, 83h, 85h and 86h read as 00h, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wr | input | 1 | SFR write enable, one cycle per write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for sfr_addr, combinational |
| xmove_stb | input | 1 | One-cycle strobe for each external data move through the pointer |
| xaddr | output | 16 | Address taken from the selected pointer |

## Verification
The hardest case to reach is an SFR write and a data-move strobe landing in the same cycle, because firmware never issues the two together. The bench drives both inputs in one cycle: once with a write to a byte of the pointer that is stepping, and once with a write to the control register while the automatic flip is armed. It then reads back the pointer and the select bit to confirm which action won. A second hard case is the background pointer. The bench sees it only by switching the selection back, so it loads distinct values into each pointer and runs the flip sequence before comparing.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

    localparam int BYTE_W   = 8;
    localparam int PTR_W    = 16;
    localparam int NUM_PTR  = 2;
    localparam int MODE_W   = 2;
    localparam int MODES_W  = NUM_PTR * MODE_W;
    localparam int HI_W     = PTR_W - BYTE_W;
    localparam int SEL_BIT  = 0;
    localparam int AUTO_BIT = 6;

    typedef enum logic [MODE_W-1:0] {
        STEP_HOLD     = 2'b00,
        STEP_UP       = 2'b01,
        STEP_DOWN     = 2'b10,
        STEP_HOLD_ALT = 2'b11
    } step_e;

    typedef struct packed {
        logic               sel;
        logic               auto_tgl;
        logic [MODES_W-1:0] modes;
    } ctl_t;

endpackage

// File: rtl/dptr_reg.sv
module dptr_reg
    import dptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step_en,
    input  step_e             mode,
    output logic [PTR_W-1:0]  ptr
);

    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (wr_lo || wr_hi) begin
            if (wr_lo) ptr_d[BYTE_W-1:0]     = wdata;
            if (wr_hi) ptr_d[PTR_W-1:BYTE_W] = wdata[HI_W-1:0];
        end else if (step_en) begin
            case (mode)
                STEP_UP:   ptr_d = ptr_q + 1'b1;
                STEP_DOWN: ptr_d = ptr_q - 1'b1;
                default:   ptr_d = ptr_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R7
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !wr_lo && !wr_hi && mode == STEP_UP)
        |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));

    // R7
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !wr_lo && !wr_hi && mode == STEP_DOWN)
        |=> ptr_q == PTR_W'($past(ptr_q) - 1'b1));

    // R6
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && (!step_en || mode == STEP_HOLD || mode == STEP_HOLD_ALT))
        |=> $stable(ptr_q));

    // R2
    hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> ptr_q[PTR_W-1:BYTE_W] == $past(ptr_q[PTR_W-1:BYTE_W]));

    // R2
    lo_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> ptr_q[BYTE_W-1:0] == $past(ptr_q[BYTE_W-1:0]));

endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
    import dptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_mode,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              stb,
    output ctl_t              ctl
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (stb && ctl_q.auto_tgl) ctl_d.sel = ~ctl_q.sel;
        if (wr_ctl) begin
            ctl_d.sel      = wdata[SEL_BIT];
            ctl_d.auto_tgl = wdata[AUTO_BIT];
        end
        if (wr_mode) ctl_d.modes = wdata[MODES_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    // R8
    auto_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ctl_q.auto_tgl && !wr_ctl) |=> ctl_q.sel != $past(ctl_q.sel));

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(stb && ctl_q.auto_tgl) && !wr_ctl) |=> $stable(ctl_q.sel));

    // R10
    ctl_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> ctl_q.sel == $past(wdata[SEL_BIT]));

endmodule

// File: rtl/dual_dptr_unit.sv
module dual_dptr_unit
    import dptr_pkg::*;
#(
    parameter logic [7:0] ADDR_LO   = 8'h82,
    parameter logic [7:0] ADDR_HI   = 8'h83,
    parameter logic [7:0] ADDR_CTL  = 8'h85,
    parameter logic [7:0] ADDR_MODE = 8'h86
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sfr_addr,
    input  logic              sfr_wr,
    input  logic [BYTE_W-1:0] sfr_wdata,
    output logic [BYTE_W-1:0] sfr_rdata,
    input  logic              xmove_stb,
    output logic [PTR_W-1:0]  xaddr
);

    ctl_t             ctl;
    logic [PTR_W-1:0] bank [NUM_PTR];
    logic             hit_lo, hit_hi, hit_ctl, hit_mode;

    assign hit_lo   = sfr_wr && (sfr_addr == ADDR_LO);
    assign hit_hi   = sfr_wr && (sfr_addr == ADDR_HI);
    assign hit_ctl  = sfr_wr && (sfr_addr == ADDR_CTL);
    assign hit_mode = sfr_wr && (sfr_addr == ADDR_MODE);

    dptr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (hit_ctl),
        .wr_mode (hit_mode),
        .wdata   (sfr_wdata),
        .stb     (xmove_stb),
        .ctl     (ctl)
    );

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_bank
        localparam logic SEL_V = 1'(g);
        logic mine;
        assign mine = (ctl.sel == SEL_V);
        dptr_reg u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (hit_lo && mine),
            .wr_hi   (hit_hi && mine),
            .wdata   (sfr_wdata),
            .step_en (xmove_stb && mine),
            .mode    (step_e'(ctl.modes[g*MODE_W +: MODE_W])),
            .ptr     (bank[g])
        );
    end

    assign xaddr = bank[ctl.sel];

    always_comb begin
        sfr_rdata = '0;
        if (sfr_addr == ADDR_LO) begin
            sfr_rdata = xaddr[BYTE_W-1:0];
        end else if (sfr_addr == ADDR_HI) begin
            sfr_rdata = BYTE_W'(xaddr[PTR_W-1:BYTE_W]);
        end else if (sfr_addr == ADDR_CTL) begin
            sfr_rdata[SEL_BIT]  = ctl.sel;
            sfr_rdata[AUTO_BIT] = ctl.auto_tgl;
        end else if (sfr_addr == ADDR_MODE) begin
            sfr_rdata[MODES_W-1:0] = ctl.modes;
        end
    end

    // R3
    background_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> bank[~$past(ctl.sel)] == $past(bank[~ctl.sel]));

    // R4
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == ADDR_CTL) |-> (sfr_rdata & 8'hBE) == 8'h00);

    // R5
    pre_step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xmove_stb && !ctl.auto_tgl && !sfr_wr && ctl.modes == '0) |=> $stable(xaddr));

endmodule

// File: tb/dual_dptr_unit_tb.sv
module dual_dptr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        xmove_stb = 1'b0;
    logic [15:0] xaddr;

    int checks = 0;
    int errors = 0;
    logic [15:0] pre_addr;

    always #10 clk = ~clk;

    dual_dptr_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .xmove_stb (xmove_stb),
        .xaddr     (xaddr)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] a, input logic w, input logic [7:0] d, input logic s);
        @(negedge clk);
        sfr_addr = a; sfr_wr = w; sfr_wdata = d; xmove_stb = s;
        #2 pre_addr = xaddr;
        @(negedge clk);
        sfr_wr = 1'b0; xmove_stb = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        cyc(a, 1'b1, d, 1'b0);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        sfr_addr = a;
        #1 v = sfr_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h85, v); chk("R1 ctl", {8'h0, v}, 16'h0000);
        rd(8'h86, v); chk("R1 mode", {8'h0, v}, 16'h0000);
        chk("R1 xaddr", xaddr, 16'h0000);
    endtask

    task automatic t_bytes();
        logic [7:0] v;
        wr(8'h82, 8'h34); wr(8'h83, 8'h12);
        chk("R2 both bytes", xaddr, 16'h1234);
        wr(8'h82, 8'hAB);
        rd(8'h83, v); chk("R2 high kept", {8'h0, v}, 16'h0012);
        rd(8'h82, v); chk("R2 low read", {8'h0, v}, 16'h00AB);
    endtask

    task automatic t_select();
        logic [7:0] v;
        wr(8'h85, 8'h01);
        rd(8'h85, v); chk("R3 sel read", {8'h0, v}, 16'h0001);
        chk("R3 ptr1 fresh", xaddr, 16'h0000);
        wr(8'h82, 8'hCD); wr(8'h83, 8'hEF);
        chk("R3 ptr1 loaded", xaddr, 16'hEFCD);
        wr(8'h85, 8'h00);
        chk("R3 ptr0 untouched", xaddr, 16'h12AB);
    endtask

    task automatic t_reserved();
        logic [7:0] v;
        wr(8'h85, 8'hFE);
        rd(8'h85, v); chk("R4 ctl reserved", {8'h0, v}, 16'h0040);
        chk("R4 sel unchanged", xaddr, 16'h12AB);
        wr(8'h85, 8'h00);
        wr(8'h86, 8'hF6);
        rd(8'h86, v); chk("R4 mode reserved", {8'h0, v}, 16'h0006);
        wr(8'h86, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(8'h84, 8'hFF);
        rd(8'h84, v); chk("R11 read 84", {8'h0, v}, 16'h0000);
        rd(8'h85, v); chk("R11 ctl kept", {8'h0, v}, 16'h0000);
        rd(8'h86, v); chk("R11 mode kept", {8'h0, v}, 16'h0000);
        chk("R11 ptr kept", xaddr, 16'h12AB);
    endtask

    task automatic t_step();
        wr(8'h86, 8'h09);
        cyc(8'h00, 1'b0, 8'h00, 1'b1);
        chk("R5 pre-step addr", pre_addr, 16'h12AB);
        chk("R6 ptr0 up", xaddr, 16'h12AC);
        wr(8'h85, 8'h01);
        cyc(8'h00, 1'b0, 8'h00, 1'b1);
        chk("R5 pre-step addr p1", pre_addr, 16'hEFCD);
        chk("R6 ptr1 down", xaddr, 16'hEFCC);
        wr(8'h86, 8'h0F);
        cyc(8'h00, 1'b0, 8'h00, 1'b1);
        chk("R6 code 11 holds", xaddr, 16'hEFCC);
        wr(8'h85, 8'h00);
        chk("R6 ptr0 not stepped by p1", xaddr, 16'h12AC);
    endtask

    task automatic t_wrap();
        wr(8'h82, 8'hFF); wr(8'h83, 8'hFF);
        wr(8'h86, 8'h01);
        cyc(8'h00, 1'b0, 8'h00, 1'b1);
        chk("R7 up wrap", xaddr, 16'h0000);
        wr(8'h86, 8'h02);
        cyc(8'h00, 1'b0, 8'h00, 1'b1);
        chk("R7 down wrap", xaddr, 16'hFFFF);
    endtask

    task automatic t_toggle();
        logic [7:0] v;
        wr(8'h82, 8'h00); wr(8'h83, 8'h10);
        wr(8'h85, 8'h01);
        wr(8'h82, 8'h00); wr(8'h83, 8'h20);
        wr(8'h86, 8'h05);
        wr(8'h85, 8'h41);
        cyc(8'h00, 1'b0, 8'h00, 1'b1);
        chk("R8 first access ptr1", pre_addr, 16'h2000);
        rd(8'h85, v); chk("R8 flipped to 0", {8'h0, v}, 16'h0040);
        chk("R8 ptr0 live", xaddr, 16'h1000);
        cyc(8'h00, 1'b0, 8'h00, 1'b1);
        chk("R8 second access ptr0", pre_addr, 16'h1000);
        rd(8'h85, v); chk("R8 flipped to 1", {8'h0, v}, 16'h0041);
        chk("R8 ptr1 stepped", xaddr, 16'h2001);
        wr(8'h85, 8'h00);
        chk("R8 ptr0 stepped", xaddr, 16'h1001);
        cyc(8'h00, 1'b0, 8'h00, 1'b1);
        rd(8'h85, v); chk("R9 no flip", {8'h0, v}, 16'h0000);
        chk("R9 single pointer step", xaddr, 16'h1002);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        cyc(8'h82, 1'b1, 8'h55, 1'b1);
        chk("R10 byte write beats step", xaddr, 16'h1055);
        wr(8'h85, 8'h40);
        cyc(8'h85, 1'b1, 8'h41, 1'b1);
        rd(8'h85, v); chk("R10 ctl write beats flip", {8'h0, v}, 16'h0041);
        wr(8'h85, 8'h00);
        chk("R10 ptr0 still stepped", xaddr, 16'h1056);
    endtask

    initial begin
        #(20 * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_bytes();
        t_select();
        t_reserved();
        t_unmapped();
        t_step();
        t_wrap();
        t_toggle();
        t_collide();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule